// File: doc/BRIEF.md
# Resonant Inverter Turn-On Delay Regulator

This block sets how long a resonant high-voltage inverter waits before it turns on its next switch. Each clock it compares the requested tube voltage with the measured voltage. It keeps the largest error seen since the previous inverter cycle. When a cycle strobe arrives, that peak error drives a fixed-point proportional-integral law.

The output of the law is subtracted from the resonance-limited maximum delay. A large positive error therefore gives a short delay, which raises the switching frequency and the delivered energy. The result is bounded below by a fixed minimum and above by the parallel-resonance time. The integrator saturates symmetrically and stops winding up while the output is pinned at either bound.

Between exposures the regulator is disabled. This empties the integrator and the peak store, and the block ignores strobes.

Top module: `kv_pi_delay`

## Requirements
- R1: The error is `kv_dem - kv_meas`, taken as a signed value one bit wider than the inputs, so a measurement above the demand gives a negative error without wrap-around.
- R2: The error used at a strobe is the largest signed error sampled on every enabled clock edge since the previous strobe edge (or since enable), counting the strobe edge itself; the store is emptied after each strobe.
- R3: At a strobe with peak error `e`: `p = floor(e*kp/2^SH)` and `inc = floor(e*ki/2^SH)` (SH=4, gains unsigned), `cand = integ + inc` saturated per R8, `raw = res_lim - (p + cand)`; when `DMIN <= raw <= res_lim` the delay is `raw` and the integrator becomes `cand`.
- R4: When `raw > res_lim` the delay equals `res_lim`, so the delay never exceeds the resonance limit.
- R5: When `raw < DMIN` (DMIN=32) the delay equals DMIN.
- R6: `delay` and `dly_vld` change only on a clock edge where `cyc_stb` and `reg_en` are both high; `dly_vld` is then high for exactly the following cycle, and at all other times `delay` holds its value.
- R7: While `reg_en` is low the integrator and the peak store are cleared and a strobe gives no `dly_vld` and leaves `delay` unchanged.
- R8: The integrator stays within ±(2^(IW-1)-1), which is ±32767 for IW=16.
- R9: When the delay is clamped to DMIN a positive increment is not accumulated; when it is clamped to `res_lim` a negative increment is not accumulated.
- R10: After reset `delay` is 0, `dly_vld` is 0 and the integrator is zero. Reset is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Regulator enable; low between exposures |
| cyc_stb | input | 1 | One-cycle strobe marking the end of an inverter cycle |
| kv_dem | input | 12 | Voltage demand, unsigned code |
| kv_meas | input | 12 | Measured voltage, unsigned code |
| kp | input | 8 | Proportional gain, scaled by 2^-4 |
| ki | input | 8 | Integral gain, scaled by 2^-4 |
| res_lim | input | 16 | Parallel-resonance time, the upper delay bound |
| delay | output | 16 | Turn-on delay for the next cycle |
| dly_vld | output | 1 | One-cycle pulse marking a new delay |

## Verification
The bench builds a multi-sample window whose largest error sits in the middle, not at the strobe edge. A detector that only tracked the last sample, or that was never emptied, would give the wrong delay. It drives small negative errors at unit gain, where truncation toward zero and flooring give different integrator values. It also pins the output at each bound and then releases it. A design without anti-windup would leave a wound-up integrator, and the following unclamped delay would be visibly off. Further tests saturate the integrator and send strobes while disabled, which exposes a missing clamp or a regulator that still responds when it should not.

// File: rtl/kvpi_pkg.sv
package kvpi_pkg;
  typedef enum logic [1:0] {
    CLP_NONE = 2'd0,
    CLP_LO   = 2'd1,
    CLP_HI   = 2'd2
  } clamp_e;
endpackage

// File: rtl/kvpi_err_peak.sv
// Forms the signed error and holds its maximum over one inverter cycle.
module kvpi_err_peak #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                stb,
  input  logic [W-1:0]        dem,
  input  logic [W-1:0]        meas,
  output logic signed [W:0]   pk_use
);
  localparam logic signed [W:0] NEG_FLOOR = {1'b1, {W{1'b0}}};

  logic signed [W:0] err;
  logic signed [W:0] pk_q;
  logic signed [W:0] pk_d;

  assign err = $signed({1'b0, dem}) - $signed({1'b0, meas});

  // the strobe edge itself is part of the window
  always_comb pk_use = (err > pk_q) ? err : pk_q;

  always_comb begin
    pk_d = pk_q;
    if (!en || stb) pk_d = NEG_FLOOR;
    else            pk_d = pk_use;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pk_q <= NEG_FLOOR;
    else        pk_q <= pk_d;
  end
endmodule

// File: rtl/kvpi_law.sv
// Combinational PI step: terms, saturation, output clamp, anti-windup.
module kvpi_law
  import kvpi_pkg::*;
#(
  parameter int W    = 12,
  parameter int G    = 8,
  parameter int SH   = 4,
  parameter int IW   = 16,
  parameter int DW   = 16,
  parameter int DMIN = 32
) (
  input  logic signed [W:0]    pk,
  input  logic [G-1:0]         kp,
  input  logic [G-1:0]         ki,
  input  logic signed [IW-1:0] integ_q,
  input  logic [DW-1:0]        res_lim,
  output logic [DW-1:0]        dly_nx,
  output logic signed [IW-1:0] integ_nx,
  output clamp_e               clamp
);
  localparam int PW = W + G + 2;
  localparam int CW = ((PW > IW) ? PW : IW) + 1;
  localparam int SW = CW + 1;
  localparam int RW = ((SW > DW + 1) ? SW : DW + 1) + 1;
  localparam logic signed [CW-1:0] I_HI   = CW'((64'sd1 <<< (IW - 1)) - 64'sd1);
  localparam logic signed [CW-1:0] I_LO   = -I_HI;
  localparam logic signed [RW-1:0] DMIN_X = RW'(DMIN);

  logic signed [PW-1:0] pk_x, p_term, i_inc;
  logic signed [CW-1:0] cand, cand_sat;
  logic signed [SW-1:0] sum;
  logic signed [RW-1:0] raw, lim_x;
  logic                 hold;

  assign pk_x   = PW'(pk);
  assign p_term = (pk_x * $signed(PW'({1'b0, kp}))) >>> SH;
  assign i_inc  = (pk_x * $signed(PW'({1'b0, ki}))) >>> SH;

  assign cand = CW'(integ_q) + CW'(i_inc);

  always_comb begin
    if (cand > I_HI)      cand_sat = I_HI;
    else if (cand < I_LO) cand_sat = I_LO;
    else                  cand_sat = cand;
  end

  assign sum   = SW'(p_term) + SW'(cand_sat);
  assign lim_x = RW'($signed({1'b0, res_lim}));
  assign raw   = lim_x - RW'(sum);

  always_comb begin
    if (raw > lim_x) begin
      clamp  = CLP_HI;
      dly_nx = res_lim;
    end else if (raw < DMIN_X) begin
      clamp  = CLP_LO;
      dly_nx = DW'(DMIN);
    end else begin
      clamp  = CLP_NONE;
      dly_nx = raw[DW-1:0];
    end
  end

  assign hold     = ((clamp == CLP_HI) && (i_inc < 0)) ||
                    ((clamp == CLP_LO) && (i_inc > 0));
  assign integ_nx = hold ? integ_q : cand_sat[IW-1:0];
endmodule

// File: rtl/kv_pi_delay.sv
module kv_pi_delay
  import kvpi_pkg::*;
#(
  parameter int W    = 12,
  parameter int G    = 8,
  parameter int SH   = 4,
  parameter int IW   = 16,
  parameter int DW   = 16,
  parameter int DMIN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          cyc_stb,
  input  logic [W-1:0]  kv_dem,
  input  logic [W-1:0]  kv_meas,
  input  logic [G-1:0]  kp,
  input  logic [G-1:0]  ki,
  input  logic [DW-1:0] res_lim,
  output logic [DW-1:0] delay,
  output logic          dly_vld
);
  logic [1:0]           rs_q;
  logic                 rst_i;
  logic signed [W:0]    pk_use;
  logic signed [IW-1:0] integ_q, integ_d, integ_nx;
  logic [DW-1:0]        dly_q, dly_d, dly_nx;
  logic                 vld_q, vld_d;
  clamp_e               clamp;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  kvpi_err_peak #(.W(W)) u_peak (
    .clk    (clk),
    .rst_n  (rst_i),
    .en     (reg_en),
    .stb    (cyc_stb),
    .dem    (kv_dem),
    .meas   (kv_meas),
    .pk_use (pk_use)
  );

  kvpi_law #(
    .W(W), .G(G), .SH(SH), .IW(IW), .DW(DW), .DMIN(DMIN)
  ) u_law (
    .pk       (pk_use),
    .kp       (kp),
    .ki       (ki),
    .integ_q  (integ_q),
    .res_lim  (res_lim),
    .dly_nx   (dly_nx),
    .integ_nx (integ_nx),
    .clamp    (clamp)
  );

  always_comb begin
    integ_d = integ_q;
    dly_d   = dly_q;
    vld_d   = 1'b0;
    if (!reg_en) begin
      integ_d = '0;
    end else if (cyc_stb) begin
      integ_d = integ_nx;
      dly_d   = dly_nx;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      integ_q <= '0;
      dly_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      integ_q <= integ_d;
      dly_q   <= dly_d;
      vld_q   <= vld_d;
    end
  end

  assign delay   = dly_q;
  assign dly_vld = vld_q;
endmodule

// File: rtl/kvpi_chk.sv
module kvpi_chk #(
  parameter int IW   = 16,
  parameter int DW   = 16,
  parameter int DMIN = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_en,
  input logic                 cyc_stb,
  input logic [DW-1:0]        res_lim,
  input logic [DW-1:0]        delay,
  input logic                 dly_vld,
  input logic signed [IW-1:0] integ_q
);
  localparam logic signed [IW-1:0] I_MAX = IW'((64'sd1 <<< (IW - 1)) - 64'sd1);

  assert_dly_le_lim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dly_vld |-> (delay <= $past(res_lim)));

  assert_dly_ge_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dly_vld |-> (delay >= DW'(DMIN)));

  assert_vld_from_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_vld |-> ($past(cyc_stb) && $past(reg_en)));

  assert_dly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_vld |-> $stable(delay));

  assert_integ_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_en) == 1'b0) |-> (integ_q == '0));

  assert_integ_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q <= I_MAX) && (integ_q >= -I_MAX));
endmodule

bind kv_pi_delay kvpi_chk #(.IW(IW), .DW(DW), .DMIN(DMIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_en  (reg_en),
  .cyc_stb (cyc_stb),
  .res_lim (res_lim),
  .delay   (delay),
  .dly_vld (dly_vld),
  .integ_q (integ_q)
);

// File: tb/sim_kv_pi_delay.sv
module sim_kv_pi_delay;
  localparam int PERIOD = 10;
  localparam int SH     = 4;
  localparam int DMIN   = 32;
  localparam longint IMAX = 32767;
  localparam int NEG    = -4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, cyc_stb;
  logic [11:0] kv_dem, kv_meas;
  logic [7:0]  kp, ki;
  logic [15:0] res_lim, delay;
  logic        dly_vld;

  int     n_vec = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  longint m_integ = 0;
  longint m_dly   = 0;
  int     m_peak  = NEG;
  bit     m_vld   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  kv_pi_delay u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .cyc_stb(cyc_stb),
    .kv_dem(kv_dem), .kv_meas(kv_meas), .kp(kp), .ki(ki),
    .res_lim(res_lim), .delay(delay), .dly_vld(dly_vld)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // independent model of one PI step (R3, R4, R5, R8, R9)
  task automatic model_law(input int pk);
    longint p, inc, cand, raw;
    bit hold;
    p    = (longint'(pk) * longint'(kp)) >>> SH;
    inc  = (longint'(pk) * longint'(ki)) >>> SH;
    cand = m_integ + inc;
    if (cand > IMAX)  cand = IMAX;
    if (cand < -IMAX) cand = -IMAX;
    raw  = longint'(res_lim) - (p + cand);
    hold = 1'b0;
    if (raw > longint'(res_lim)) begin
      m_dly = res_lim; hold = (inc < 0);
    end else if (raw < DMIN) begin
      m_dly = DMIN;    hold = (inc > 0);
    end else begin
      m_dly = raw;
    end
    if (!hold) m_integ = cand;
  endtask

  // one clock edge: drive at negedge, check a quarter period after posedge
  task automatic tick(input int dem, input int meas, input bit stb, input string tag);
    int e, pk;
    @(negedge clk);
    kv_dem = 12'(dem); kv_meas = 12'(meas); cyc_stb = stb;
    e = dem - meas;
    if (!reg_en) begin
      m_peak = NEG; m_integ = 0; m_vld = 1'b0;
    end else begin
      pk = (e > m_peak) ? e : m_peak;
      if (stb) begin
        model_law(pk); m_peak = NEG; m_vld = 1'b1;
      end else begin
        m_peak = pk; m_vld = 1'b0;
      end
    end
    @(posedge clk); #(PERIOD/4);
    chk(tag, "dly_vld", dly_vld, m_vld);
    chk(tag, "delay", delay, m_dly);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; reg_en = 1'b0; cyc_stb = 1'b0;
    kv_dem = '0; kv_meas = '0; kp = '0; ki = '0; res_lim = 16'd1000;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R10", "delay in reset", delay, 0);
    chk("R10", "dly_vld in reset", dly_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick(0, 0, 1'b1, "R10");
  endtask

  task automatic t_prop;
    reg_en = 1'b1; kp = 8'd16; ki = 8'd0; res_lim = 16'd1000;
    tick(600, 500, 1'b1, "R3");      // e=100 -> 900
    tick(600, 600, 1'b0, "R6");      // pulse ends, delay held
    tick(600, 300, 1'b1, "R3");      // larger error -> shorter delay 700
    tick(500, 700, 1'b1, "R4");      // raw 1200 clamps to 1000
  endtask

  task automatic t_peak;
    tick(600, 550, 1'b0, "R2");
    tick(600, 450, 1'b0, "R2");
    tick(600, 580, 1'b1, "R2");      // peak 150 -> 850
    tick(600, 590, 1'b1, "R2");      // store emptied -> 990
  endtask

  task automatic t_integ;
    kp = 8'd0; ki = 8'd16;
    tick(600, 550, 1'b1, "R3");      // 950
    tick(600, 550, 1'b1, "R3");      // 900
    tick(580, 600, 1'b1, "R1");      // negative error -> 920
    ki = 8'd1;
    tick(593, 600, 1'b1, "R3");      // floor(-7/16) = -1 -> 921
  endtask

  task automatic t_lo;
    kp = 8'd255; ki = 8'd0;
    tick(4095, 0, 1'b1, "R5");
  endtask

  task automatic t_disable;
    reg_en = 1'b0;
    tick(600, 500, 1'b1, "R7");
    tick(600, 500, 1'b1, "R7");
    reg_en = 1'b1; kp = 8'd0; ki = 8'd16;
    tick(600, 600, 1'b1, "R7");      // integrator empty -> res_lim
  endtask

  task automatic t_awu;
    res_lim = 16'd200; kp = 8'd0; ki = 8'd255;
    tick(4095, 95, 1'b1, "R9");      // pinned at DMIN, no accumulate
    ki = 8'd16;
    tick(700, 600, 1'b1, "R9");      // 100
    tick(0, 4000, 1'b1, "R9");       // pinned at limit, no accumulate
    tick(600, 600, 1'b1, "R9");      // back to 100
  endtask

  task automatic t_sat;
    reg_en = 1'b0;
    tick(0, 0, 1'b0, "R8");
    reg_en = 1'b1; res_lim = 16'hFFFF; kp = 8'd0; ki = 8'd255;
    tick(4095, 0, 1'b1, "R8");       // 32768
    tick(4095, 0, 1'b1, "R8");       // still 32768
    ki = 8'd16;
    tick(600, 616, 1'b1, "R8");      // 32767-16 -> 32784
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prop();
    t_peak();
    t_integ();
    t_lo();
    t_disable();
    t_awu();
    t_sat();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule